// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Direction Override

This block is an I/O port of a configurable width, eight pins by default. It is controlled through a small synchronous register bus. Three registers sit on the bus. A direction register picks, per pin, whether the pin drives or listens. An output latch holds the value that the driving pins present. A read-only pin-level register shows every pin after a two-flop synchronizer clocked by the bus clock.

A PWM peripheral can take over pins. When one of its channels is enabled, that pin becomes an output and drives the channel value, whatever its stored direction bit says. A shutdown input forces the highest pin back to input, and this wins over the PWM override on that pin. Neither override ever alters the stored direction bits, so software reads back exactly what it wrote.

Software can compare the pin-level register with what it drove, to spot a shorted or overloaded output. A read of the output-latch address is mixed per pin: pins that are effectively outputs return the latch, and pins that are effectively inputs return the synchronized level.

Top module: `gpio_port_ovr`

## Requirements
- R1: With no PWM channel enabled and shutdown low, `pin_oe[i]` equals the stored direction bit i (1 = output, 0 = input).
- R2: After reset the direction register and output latch are all zeros, so `pin_oe` is 0 and `pin_out` is 0.
- R3: The direction register sits at address 1. It can be written at any time, and a read returns the last value written.
- R4: With `pwm_en[i]` high (and for the top pin, shutdown low), `pin_oe[i]` is 1 and `pin_out[i]` equals `pwm_val[i]`. The value read from the direction register is unchanged.
- R5: With `pwm_shutdown` high, `pin_oe` of the top pin is 0 even when its direction bit and `pwm_en` bit are set. The stored direction bit is not modified.
- R6: The pin-level register at address 2 returns `pin_in` delayed by exactly two clock edges, for output pins as well as input pins.
- R7: A read of address 0 returns, per pin, the output latch if the pin is effectively an output, and the synchronized pin level otherwise.
- R8: A pin that is an output without a PWM override drives the matching bit of the output latch, which is written at address 0.
- R9: Writes to address 2 change no register, and a read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on a clock edge |
| bus_addr | input | 2 | Register select: 0 latch, 1 direction, 2 pin levels |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data of the selected register (combinational) |
| pin_in | input | WIDTH | Levels seen on the pins |
| pin_out | output | WIDTH | Value driven onto each pin |
| pin_oe | output | WIDTH | Per-pin drive enable |
| pwm_en | input | WIDTH | Per-pin PWM channel enable |
| pwm_val | input | WIDTH | Per-pin PWM channel output value |
| pwm_shutdown | input | 1 | Forces the top pin to input |

## Verification
Several rules are checked on every cycle by the assertions. A direction write lands one edge later, and a write to the pin-level address leaves both stored registers unchanged. The synchronizer output equals the pin input from two edges earlier. An enabled PWM channel always raises its drive enable, and shutdown always keeps the top pin undriven. Only the bench scenarios show the mixed per-pin read of the latch address, the exact cycle in which a pin change becomes visible, and the read-back of direction bits that the overrides left intact. These scenarios also show what the pins drive under each combination of the two overrides.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_LATCH = 2'd0,
    REG_DIR   = 2'd1,
    REG_PINS  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_raw,
  output logic [WIDTH-1:0] pins_sync
);
  logic [WIDTH-1:0] stage1_q, stage1_d;
  logic [WIDTH-1:0] stage2_q, stage2_d;
  logic [1:0]       age_q, age_d;

  always_comb begin
    stage1_d = pins_raw;
    stage2_d = stage1_q;
    age_d    = (age_q == 2'd2) ? age_q : age_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      age_q    <= '0;
    end else begin
      stage1_q <= stage1_d;
      stage2_q <= stage2_d;
      age_q    <= age_d;
    end
  end

  assign pins_sync = stage2_q;

  // R6: the visible level lags the raw pins by exactly two edges
  a_r6_two_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (pins_sync == $past(pins_raw, 2)));
endmodule

// File: rtl/gpio_dir_resolve.sv
module gpio_dir_resolve #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_bits,
  input  logic [WIDTH-1:0] pwm_en,
  input  logic             pwm_shutdown,
  output logic [WIDTH-1:0] eff_out,
  output logic [WIDTH-1:0] pwm_owns
);
  localparam int TOP = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i == TOP) begin : g_top
      always_comb begin
        pwm_owns[i] = pwm_en[i] && !pwm_shutdown;
        eff_out[i]  = !pwm_shutdown && (pwm_en[i] || dir_bits[i]);
      end
    end else begin : g_plain
      always_comb begin
        pwm_owns[i] = pwm_en[i];
        eff_out[i]  = pwm_en[i] || dir_bits[i];
      end
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  eff_out,
  input  logic [WIDTH-1:0]  pins_sync,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  latch_q,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] dir_d, latch_d;
  logic             dir_en, latch_en;

  always_comb begin
    dir_en   = we && (addr == REG_DIR);
    latch_en = we && (addr == REG_LATCH);
    dir_d    = dir_en   ? wdata : dir_q;
    latch_d  = latch_en ? wdata : latch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      latch_q <= '0;
    end else begin
      dir_q   <= dir_d;
      latch_q <= latch_d;
    end
  end

  always_comb begin
    case (addr)
      REG_LATCH: rdata = (latch_q & eff_out) | (pins_sync & ~eff_out);
      REG_DIR:   rdata = dir_q;
      REG_PINS:  rdata = pins_sync;
      default:   rdata = '0;
    endcase
  end

  // R3: a direction write is stored on the next edge
  a_r3_dir_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == REG_DIR) |=> (dir_q == $past(wdata)));

  // R9: the pin-level address is read-only
  a_r9_pins_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == REG_PINS) |=> ($stable(dir_q) && $stable(latch_q)));

  // R4, R5: only a bus write alters the stored direction bits
  a_r4_dir_only_by_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == REG_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  input  logic [WIDTH-1:0]  pwm_en,
  input  logic [WIDTH-1:0]  pwm_val,
  input  logic              pwm_shutdown
);
  localparam int TOP = WIDTH - 1;

  logic             rst_meta_q, rst_sync_q;
  logic [WIDTH-1:0] pins_sync, dir_q, latch_q, eff_out, pwm_owns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  gpio_pin_sync #(.WIDTH(WIDTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .pins_raw (pin_in),
    .pins_sync(pins_sync)
  );

  gpio_dir_resolve #(.WIDTH(WIDTH)) u_resolve (
    .dir_bits    (dir_q),
    .pwm_en      (pwm_en),
    .pwm_shutdown(pwm_shutdown),
    .eff_out     (eff_out),
    .pwm_owns    (pwm_owns)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .addr     (bus_addr),
    .we       (bus_we),
    .wdata    (bus_wdata),
    .eff_out  (eff_out),
    .pins_sync(pins_sync),
    .dir_q    (dir_q),
    .latch_q  (latch_q),
    .rdata    (bus_rdata)
  );

  always_comb begin
    pin_oe  = eff_out;
    pin_out = (pwm_val & pwm_owns) | (latch_q & ~pwm_owns);
  end

  // R5: shutdown keeps the top pin undriven
  a_r5_shutdown_top_input: assert property (@(posedge clk) disable iff (!rst_sync_q)
    pwm_shutdown |-> !pin_oe[TOP]);

  // R4: every enabled channel below the top pin drives
  a_r4_pwm_forces_oe: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ((pwm_en[TOP-1:0] & ~pin_oe[TOP-1:0]) == '0));

  // R1: without overrides the stored direction alone sets the drive
  a_r1_dir_sets_oe: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (pwm_en == '0 && !pwm_shutdown) |-> (pin_oe == dir_q));
endmodule

// File: tb/gpio_port_ovr_test.sv
module gpio_port_ovr_test;
  localparam int W = 8;

  typedef struct {
    int         kind;   // 0 read data, 1 drive enable, 2 pin values
    logic [W-1:0] exp;
    string      tag;
  } sb_item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe;
  logic [W-1:0] pwm_en = '0;
  logic [W-1:0] pwm_val = '0;
  logic         pwm_shutdown = 1'b0;

  sb_item_t sb_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port_ovr #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pwm_en(pwm_en),
    .pwm_val(pwm_val), .pwm_shutdown(pwm_shutdown)
  );

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic expect_rd(input logic [1:0] a, input logic [W-1:0] e, input string t);
    sb_item_t it;
    @(negedge clk);
    bus_addr = a;
    it.kind = 0; it.exp = e; it.tag = t;
    sb_q.push_back(it);
  endtask

  task automatic expect_pin(input int k, input logic [W-1:0] e, input string t);
    sb_item_t it;
    @(negedge clk);
    it.kind = k; it.exp = e; it.tag = t;
    sb_q.push_back(it);
  endtask

  task automatic set_pins(input logic [W-1:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  // monitor: pops expected items and compares just after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        sb_item_t it;
        logic [W-1:0] act;
        it = sb_q.pop_front();
        act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? pin_oe : pin_out;
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    expect_rd(2'd1, 8'h00, "R2 dir reset");
    expect_pin(1, 8'h00, "R2 oe reset");
    expect_pin(2, 8'h00, "R2 out reset");

    wr(2'd1, 8'h0F);
    expect_rd(2'd1, 8'h0F, "R3 dir readback");
    expect_pin(1, 8'h0F, "R1 oe follows dir");

    wr(2'd0, 8'h3C);
    expect_pin(2, 8'h3C, "R8 out from latch");
    set_pins(8'hA5);
    repeat (2) @(negedge clk);
    expect_rd(2'd0, 8'hAC, "R7 mixed latch read");
    expect_rd(2'd2, 8'hA5, "R6 pins incl outputs");

    set_pins(8'h5A);
    expect_rd(2'd2, 8'hA5, "R6 one edge not yet");
    expect_rd(2'd2, 8'h5A, "R6 two edges visible");

    @(negedge clk); pwm_en = 8'h81; pwm_val = 8'h01;
    expect_pin(1, 8'h8F, "R4 pwm forces oe");
    expect_pin(2, 8'h3D, "R4 pwm value driven");
    expect_rd(2'd1, 8'h0F, "R4 dir untouched");
    expect_rd(2'd0, 8'h5C, "R7 read with pwm outputs");

    @(negedge clk); pwm_shutdown = 1'b1;
    expect_pin(1, 8'h0F, "R5 shutdown top input");
    wr(2'd1, 8'hFF);
    expect_pin(1, 8'h7F, "R5 shutdown beats dir");
    expect_rd(2'd1, 8'hFF, "R5 dir bit kept");
    expect_pin(2, 8'h3D, "R8 top pin back to latch");

    @(negedge clk); pwm_shutdown = 1'b0; pwm_en = '0;
    expect_pin(1, 8'hFF, "R1 all outputs");

    wr(2'd2, 8'h00);
    expect_rd(2'd1, 8'hFF, "R9 dir after pins write");
    expect_rd(2'd0, 8'h3C, "R9 latch after pins write");
    expect_rd(2'd3, 8'h00, "R9 unmapped reads zero");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule